// File: doc/BRIEF.md
# Tracking Position Counter Output Latch

This block sits between the up/down position counter of a tracking angle converter and a shared byte-wide bus. Single-step up or down strobes move an internal position count. Each step raises a one-cycle busy pulse, and that pulse copies the count into a set of output latches. A host reads the latches one byte at a time.

An active-low hold input freezes the latches while the count keeps tracking. A ready flag rises a fixed number of cycles after hold is sampled low. At that point any latch update that was already under way has finished, and the frozen value is safe to read. Releasing hold sends a refresh busy pulse that reloads the latches with the current count. An active-low output enable drives two byte lanes. The primary lane carries the high or the low byte, chosen by a select input. The secondary lane always carries the low byte. The resolution can be set to 10, 12, 14 or 16 bits.

A transfer state machine has four states. In XF_TRACK the latches follow every step. In XF_SETTLE the latches are frozen and the validity delay is counted. In XF_FROZEN the latches are frozen and the ready flag is high. XF_REFRESH is a single cycle that reloads the latches. The transitions are:
- XF_TRACK to XF_SETTLE when hold is sampled low.
- XF_SETTLE to XF_FROZEN when the delay count expires.
- XF_SETTLE or XF_FROZEN to XF_REFRESH when hold is sampled high.
- XF_REFRESH to XF_TRACK, or back to XF_SETTLE if hold is already low again.

Top module: `trk_pos_latch`

## Requirements
- R1: When exactly one of step_up and step_dn is sampled high, the count moves by one and busy is high for the next cycle. The latches take the new count at the clock edge that ends that busy cycle. When both strobes or neither are high, the count does not change and no busy pulse is raised.
- R2: The res_code input sets the resolution: 0 gives 10 bits, 1 gives 12, 2 gives 14 and 3 gives 16. The count wraps modulo 2 to the power of the resolution in both directions.
- R3: While the state machine is in XF_SETTLE or XF_FROZEN, steps still change the count and still raise busy, but the latches do not change. Latch updates requested during hold are dropped, not queued.
- R4: A latch update is still completed in two cases: when busy is already high at the edge where hold is first sampled low, and when a step is sampled at that same edge.
- R5: hold_ready rises exactly VALID_DLY clock edges after the edge that first samples hold_n low. It stays low while the block is tracking or settling.
- R6: When hold_n is sampled high in XF_SETTLE or XF_FROZEN, busy is high for one cycle (XF_REFRESH). The latches then take the current count at the end of that cycle.
- R7: With oe_n high, lane_oe is 0 and both lanes are high impedance. With oe_n low, lane_oe is 1 and the lanes are driven. oe_n has no effect on counting.
- R8: Define the 16-bit output word as the latched count shifted left by (16 minus the resolution). With hi_sel at 1, lane_a carries word bits 15:8. With hi_sel at 0, lane_a carries word bits 7:0.
- R9: lane_b always carries word bits 7:0, whatever the value of hi_sel.
- R10: At resolutions below 16, the value is aligned to the most significant end of the word, and the unused low word bits read 0.
- R11: Holding rst_n low at a clock edge clears the count, the latches and busy, and returns the state machine to XF_TRACK.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| step_up | input | 1 | One-cycle increment strobe |
| step_dn | input | 1 | One-cycle decrement strobe |
| res_code | input | 2 | Resolution select (10/12/14/16 bits) |
| hold_n | input | 1 | Active-low latch freeze |
| oe_n | input | 1 | Active-low lane output enable |
| hi_sel | input | 1 | Selects the high byte on lane_a when 1 |
| busy | output | 1 | Latch update pulse |
| hold_ready | output | 1 | Frozen latch data is valid |
| lane_oe | output | 1 | Lanes are being driven |
| lane_a | output | 8 | Primary byte lane, tri-stated |
| lane_b | output | 8 | Low byte lane, tri-stated |

## Verification
The bench builds the block with VALID_DLY at 4, so the settle window closes within a few cycles. This lets one run test hold, ready, release and the in-flight edge case several times over. MAX_W stays at 16 and LANE_W at 8. With those values, a single down-step from zero reaches the all-ones wrap at every resolution code. The vector table can therefore check the alignment and zero padding for 10, 12, 14 and 16 bits using short step counts.

// File: rtl/trk_latch_pkg.sv
package trk_latch_pkg;

    typedef enum logic [1:0] {
        XF_TRACK   = 2'd0,
        XF_SETTLE  = 2'd1,
        XF_FROZEN  = 2'd2,
        XF_REFRESH = 2'd3
    } xfer_state_e;

    // Left shift that aligns a count of the selected resolution to the
    // top of a 16-bit word: code 0..3 -> 10..16 bits -> shift 6..0.
    function automatic logic [2:0] res_shift(input logic [1:0] code);
        return 3'd6 - {code, 1'b0};
    endfunction

endpackage

// File: rtl/trk_step_counter.sv
module trk_step_counter
    import trk_latch_pkg::*;
#(
    parameter int unsigned MAX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_up,
    input  logic             step_dn,
    input  logic [1:0]       res_code,
    output logic [MAX_W-1:0] cnt_q,
    output logic             step_ev
);

    localparam logic [MAX_W-1:0] ONE = MAX_W'(1);

    logic [MAX_W-1:0] mask;
    logic             go_up;
    logic             go_dn;

    always_comb begin
        mask  = {MAX_W{1'b1}} >> res_shift(res_code);
        go_up = step_up && !step_dn;
        go_dn = step_dn && !step_up;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            step_ev <= 1'b0;
        end else begin
            step_ev <= go_up || go_dn;
            if (go_up) begin
                cnt_q <= (cnt_q + ONE) & mask;
            end else if (go_dn) begin
                cnt_q <= (cnt_q - ONE) & mask;
            end
        end
    end

endmodule

// File: rtl/trk_xfer_fsm.sv
module trk_xfer_fsm
    import trk_latch_pkg::*;
#(
    parameter int unsigned VALID_DLY = 49
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold_n,
    input  logic step_ev,
    output logic latch_load,
    output logic busy,
    output logic hold_ready
);

    localparam int unsigned DLY_W   = $clog2(VALID_DLY + 1);
    localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(VALID_DLY - 1);

    xfer_state_e      state_q;
    xfer_state_e      state_d;
    logic [DLY_W-1:0] settle_q;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= XF_TRACK;
        end else begin
            state_q <= state_d;
        end
    end

    // Settle-window counter
    always_ff @(posedge clk) begin
        if (!rst_n || state_q != XF_SETTLE) begin
            settle_q <= '0;
        end else begin
            settle_q <= settle_q + DLY_W'(1);
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            XF_TRACK:   if (!hold_n) state_d = XF_SETTLE;
            XF_SETTLE: begin
                if (hold_n) begin
                    state_d = XF_REFRESH;
                end else if (settle_q == DLY_LAST) begin
                    state_d = XF_FROZEN;
                end
            end
            XF_FROZEN:  if (hold_n) state_d = XF_REFRESH;
            XF_REFRESH: state_d = hold_n ? XF_TRACK : XF_SETTLE;
            default:    state_d = XF_TRACK;
        endcase
    end

    // Outputs
    always_comb begin
        latch_load = 1'b0;
        busy       = step_ev;
        hold_ready = 1'b0;
        unique case (state_q)
            XF_TRACK:   latch_load = step_ev;
            XF_SETTLE:  latch_load = step_ev && (settle_q == '0);
            XF_FROZEN:  hold_ready = 1'b1;
            XF_REFRESH: begin
                latch_load = 1'b1;
                busy       = 1'b1;
            end
            default:    latch_load = 1'b0;
        endcase
    end

endmodule

// File: rtl/trk_lane_mux.sv
module trk_lane_mux
    import trk_latch_pkg::*;
#(
    parameter int unsigned MAX_W  = 16,
    parameter int unsigned LANE_W = 8
) (
    input  logic [MAX_W-1:0]  latch_q,
    input  logic [1:0]        res_code,
    input  logic              hi_sel,
    output logic [LANE_W-1:0] pri_val,
    output logic [LANE_W-1:0] sec_val
);

    localparam int unsigned NBYTE = MAX_W / LANE_W;

    logic [MAX_W-1:0]  mask;
    logic [MAX_W-1:0]  word;
    logic [LANE_W-1:0] bytes [NBYTE];

    always_comb begin
        mask = {MAX_W{1'b1}} >> res_shift(res_code);
        word = (latch_q & mask) << res_shift(res_code);
    end

    for (genvar b = 0; b < NBYTE; b++) begin : g_byte
        assign bytes[b] = word[b*LANE_W +: LANE_W];
    end

    always_comb begin
        sec_val = bytes[0];
        pri_val = hi_sel ? bytes[NBYTE-1] : bytes[0];
    end

endmodule

// File: rtl/trk_pos_latch.sv
module trk_pos_latch
    import trk_latch_pkg::*;
#(
    parameter int unsigned MAX_W     = 16,
    parameter int unsigned LANE_W    = 8,
    parameter int unsigned VALID_DLY = 49
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step_up,
    input  logic              step_dn,
    input  logic [1:0]        res_code,
    input  logic              hold_n,
    input  logic              oe_n,
    input  logic              hi_sel,
    output logic              busy,
    output logic              hold_ready,
    output logic              lane_oe,
    output logic [LANE_W-1:0] lane_a,
    output logic [LANE_W-1:0] lane_b
);

    logic [MAX_W-1:0]  cnt_q;
    logic              step_ev;
    logic              latch_load;
    logic [MAX_W-1:0]  latch_q;
    logic [LANE_W-1:0] pri_val;
    logic [LANE_W-1:0] sec_val;

    trk_step_counter #(.MAX_W(MAX_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_up  (step_up),
        .step_dn  (step_dn),
        .res_code (res_code),
        .cnt_q    (cnt_q),
        .step_ev  (step_ev)
    );

    trk_xfer_fsm #(.VALID_DLY(VALID_DLY)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold_n     (hold_n),
        .step_ev    (step_ev),
        .latch_load (latch_load),
        .busy       (busy),
        .hold_ready (hold_ready)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (latch_load) begin
            latch_q <= cnt_q;
        end
    end

    trk_lane_mux #(.MAX_W(MAX_W), .LANE_W(LANE_W)) u_mux (
        .latch_q  (latch_q),
        .res_code (res_code),
        .hi_sel   (hi_sel),
        .pri_val  (pri_val),
        .sec_val  (sec_val)
    );

    assign lane_oe = !oe_n;
    assign lane_a  = oe_n ? 'z : pri_val;
    assign lane_b  = oe_n ? 'z : sec_val;

endmodule

// File: rtl/trk_pos_latch_chk.sv
module trk_pos_latch_chk #(
    parameter int unsigned MAX_W  = 16,
    parameter int unsigned LANE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_up,
    input logic              step_dn,
    input logic              hold_n,
    input logic              oe_n,
    input logic              hi_sel,
    input logic              busy,
    input logic              hold_ready,
    input logic [LANE_W-1:0] lane_a,
    input logic [LANE_W-1:0] lane_b,
    input logic [MAX_W-1:0]  latch_q
);

    assert_step_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (step_up ^ step_dn) |=> busy);

    assert_frozen_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ready |=> $stable(latch_q));

    assert_ready_after_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hold_ready |-> $past(!hold_n));

    assert_release_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_ready && hold_n) |=> busy);

    assert_low_lane_dup_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_n && !hi_sel) |-> (lane_a == lane_b));

endmodule

bind trk_pos_latch trk_pos_latch_chk #(.MAX_W(MAX_W), .LANE_W(LANE_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .step_up    (step_up),
    .step_dn    (step_dn),
    .hold_n     (hold_n),
    .oe_n       (oe_n),
    .hi_sel     (hi_sel),
    .busy       (busy),
    .hold_ready (hold_ready),
    .lane_a     (lane_a),
    .lane_b     (lane_b),
    .latch_q    (latch_q)
);

// File: tb/trk_pos_latch_tb.sv
module trk_pos_latch_tb_top;

    localparam int unsigned DLY = 4;

    typedef struct packed {
        logic [1:0] res;
        logic [7:0] n_up;
        logic [7:0] n_dn;
        logic       hi;
        logic [7:0] exp_a;
        logic [7:0] exp_b;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd3, 8'd5,  8'd0, 1'b0, 8'h05, 8'h05},
        '{2'd3, 8'd0,  8'd1, 1'b1, 8'hFF, 8'hFF},
        '{2'd0, 8'd0,  8'd1, 1'b1, 8'hFF, 8'hC0},
        '{2'd0, 8'd3,  8'd0, 1'b1, 8'h00, 8'hC0},
        '{2'd1, 8'd0,  8'd2, 1'b1, 8'hFF, 8'hE0},
        '{2'd2, 8'd7,  8'd2, 1'b0, 8'h14, 8'h14},
        '{2'd2, 8'd7,  8'd2, 1'b1, 8'h00, 8'h14},
        '{2'd1, 8'd20, 8'd0, 1'b0, 8'h40, 8'h40}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       step_up = 1'b0;
    logic       step_dn = 1'b0;
    logic [1:0] res_code = 2'd3;
    logic       hold_n = 1'b1;
    logic       oe_n = 1'b0;
    logic       hi_sel = 1'b0;
    logic       busy;
    logic       hold_ready;
    logic       lane_oe;
    wire  [7:0] lane_a;
    wire  [7:0] lane_b;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    trk_pos_latch #(.MAX_W(16), .LANE_W(8), .VALID_DLY(DLY)) dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .step_up    (step_up),
        .step_dn    (step_dn),
        .res_code   (res_code),
        .hold_n     (hold_n),
        .oe_n       (oe_n),
        .hi_sel     (hi_sel),
        .busy       (busy),
        .hold_ready (hold_ready),
        .lane_oe    (lane_oe),
        .lane_a     (lane_a),
        .lane_b     (lane_b)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; step_up = 1'b0; step_dn = 1'b0; hold_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Drive one step, return two cycles later with the latch updated.
    task automatic pulse(input logic up, input logic dn);
        @(negedge clk);
        step_up = up; step_dn = dn;
        @(negedge clk);
        step_up = 1'b0; step_dn = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        // Vector table: R2, R8, R9, R10
        for (int v = 0; v < 8; v++) begin
            res_code = VECS[v].res;
            hi_sel   = VECS[v].hi;
            do_reset();
            for (int i = 0; i < int'(VECS[v].n_up); i++) pulse(1'b1, 1'b0);
            for (int i = 0; i < int'(VECS[v].n_dn); i++) pulse(1'b0, 1'b1);
            check($sformatf("R8 R10 lane_a vec%0d", v), {8'h0, lane_a}, {8'h0, VECS[v].exp_a});
            check($sformatf("R9 R2 lane_b vec%0d", v), {8'h0, lane_b}, {8'h0, VECS[v].exp_b});
        end

        // R11 reset state
        res_code = 2'd3; hi_sel = 1'b1; oe_n = 1'b0;
        do_reset();
        @(negedge clk);
        check("R11 busy", {15'h0, busy}, 16'h0);
        check("R11 hold_ready", {15'h0, hold_ready}, 16'h0);
        check("R11 lanes", {lane_a, lane_b}, 16'h0000);
        check("R7 lane_oe on", {15'h0, lane_oe}, 16'h1);

        // R1 busy timing and latch update
        step_up = 1'b1;
        @(negedge clk);
        step_up = 1'b0;
        check("R1 busy high", {15'h0, busy}, 16'h1);
        check("R1 latch old", {lane_a, lane_b}, 16'h0000);
        @(negedge clk);
        check("R1 busy low", {15'h0, busy}, 16'h0);
        check("R1 latch new", {lane_a, lane_b}, 16'h0001);

        // R1 simultaneous strobes
        step_up = 1'b1; step_dn = 1'b1;
        @(negedge clk);
        step_up = 1'b0; step_dn = 1'b0;
        check("R1 both no busy", {15'h0, busy}, 16'h0);
        @(negedge clk);
        check("R1 both no change", {lane_a, lane_b}, 16'h0001);

        // R5 ready delay, R3 frozen latches
        hold_n = 1'b0;
        repeat (DLY) @(negedge clk);
        check("R5 not ready yet", {15'h0, hold_ready}, 16'h0);
        @(negedge clk);
        check("R5 ready", {15'h0, hold_ready}, 16'h1);
        step_up = 1'b1;
        @(negedge clk);
        step_up = 1'b0;
        check("R3 busy while held", {15'h0, busy}, 16'h1);
        @(negedge clk);
        pulse(1'b1, 1'b0);
        pulse(1'b1, 1'b0);
        check("R3 latch frozen", {lane_a, lane_b}, 16'h0001);

        // R6 release refresh
        hold_n = 1'b1;
        @(negedge clk);
        check("R6 refresh busy", {15'h0, busy}, 16'h1);
        check("R5 ready drops", {15'h0, hold_ready}, 16'h0);
        @(negedge clk);
        check("R6 busy ends", {15'h0, busy}, 16'h0);
        check("R6 refreshed count", {lane_a, lane_b}, 16'h0004);

        // R4 step sampled at the same edge as hold
        step_up = 1'b1; hold_n = 1'b0;
        @(negedge clk);
        step_up = 1'b0;
        @(negedge clk);
        check("R4 in-flight lands", {lane_a, lane_b}, 16'h0005);
        pulse(1'b1, 1'b0);
        check("R3 later step dropped", {lane_a, lane_b}, 16'h0005);
        hold_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 second refresh", {lane_a, lane_b}, 16'h0006);

        // R7 output enable
        oe_n = 1'b1;
        @(negedge clk);
        check("R7 lane_oe off", {15'h0, lane_oe}, 16'h0);
        pulse(1'b1, 1'b0);
        oe_n = 1'b0;
        @(negedge clk);
        check("R7 counted while off", {lane_a, lane_b}, 16'h0007);
        hi_sel = 1'b0;
        @(negedge clk);
        check("R8 low byte on lane_a", {lane_a, lane_b}, 16'h0707);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule